// File: doc/BRIEF.md
# Byte-Wide Flash Host Bus Front End

This block sits between the asynchronous host pins of a byte-wide flash part and the synchronous logic behind them. A fast internal clock oversamples the three active-low control strobes: chip select, output enable and write strobe. Each strobe passes through a two-flop synchroniser. The synchronised strobes then decide when the read data bus is driven and when it is released.

For write cycles, the address is taken when the second of the two write-side strobes has fallen. The data is taken when the first of them rises. The result is handed to a command interpreter as a one-cycle command pulse with its address and data. The command latch has no readable address of its own. Reads return either array data, supplied from outside, or an identifier byte. The identifier path is selected by a high-voltage detect flag and is indexed only by the two lowest address bits.

Top module: `flash_bus_front`

## Requirements
- R1: While reset is asserted, and right after it is released, `rd_en` is 0, `rd_data` is 0x00, `cmd_valid` is 0, and `cmd_addr` and `cmd_data` are 0.
- R2: `rd_en` is 1 exactly when both `cs_n_pin` and `oe_n_pin` have been low for two clock edges. While `rd_en` is 0, `rd_data` is 0x00, which models a bus in high impedance.
- R3: While chip select is high (standby), `rd_en` stays 0 whatever the levels of output enable and write strobe.
- R4: A read with `id_hv` low returns `arr_rdata` unchanged.
- R5: A read with `id_hv` high returns an identifier chosen by address bits 1:0. The value 00 gives MFR_ID (default 0xDA), 01 gives DEV_ID (default 0x0B), and 10 or 11 give 0x00. All other address bits have no effect on this result.
- R6: A write cycle is open only while chip select and write strobe are both low and output enable is high. Strobes that are low while output enable is low produce no command, and `cmd_addr` and `cmd_data` keep their values.
- R7: `cmd_addr` is the address present when the later of the two falling strobes (chip select or write strobe) is seen, whichever of them falls last.
- R8: `cmd_data` is the data present when the earlier of the two rising strobes is seen, whichever of them rises first. A strobe that rises after that one has no effect.
- R9: A completed write raises `cmd_valid` for exactly one clock. It goes high after the third rising clock edge that follows the first strobe rising. `cmd_addr` and `cmd_data` hold their values until the next completed write.
- R10: If output enable goes low while a write cycle is open, the cycle is abandoned. No `cmd_valid` follows, even when the strobes later rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| cs_n_pin | input | 1 | Asynchronous active-low chip select |
| oe_n_pin | input | 1 | Asynchronous active-low output enable |
| we_n_pin | input | 1 | Asynchronous active-low write strobe |
| addr | input | AW (18) | Host address |
| wdata | input | DW (8) | Host write data |
| id_hv | input | 1 | High-voltage detect flag that selects identifier reads |
| arr_rdata | input | DW (8) | Array read data for the current address |
| rd_data | output | DW (8) | Read data toward the host; 0x00 when released |
| rd_en | output | 1 | Output driver enable; 0 means high impedance |
| cmd_valid | output | 1 | One-cycle pulse when a write completes |
| cmd_addr | output | AW (18) | Captured write address |
| cmd_data | output | DW (8) | Captured write data |

## Verification
All eight combinations of the three strobe levels are swept. This separates correct read gating from gating that ignores chip select or output enable, and shows that the write strobe does not affect reads. Identifier reads are swept over every value of the two low address bits, each with several upper-bit patterns. This catches a wrong mux index, and any dependence on bits that should be ignored. Write cycles are run in both falling orders and both rising orders, with the address and data changed between the strobe edges, so that capture on the wrong edge shows up as a wrong value. An output-enable abort and a write with output enable low show that the command pulse appears only for a valid, completed cycle, and the latency of that pulse is checked clock by clock.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  // Synchronised control strobes, all active low.
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } strb_t;

  localparam int unsigned STRB_W = 3;

  // Identifier select codes on address bits 1:0.
  localparam logic [1:0] IDSEL_MFR = 2'b00;
  localparam logic [1:0] IDSEL_DEV = 2'b01;

endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_i[b]};
    end

    // Strobes are inactive-high, so reset fills the chain with ones.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/fbf_wr_latch.sv
module fbf_wr_latch
  import fbf_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strb_t         strb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);

  logic          open_q, open_d;
  logic [AW-1:0] ahold_q, ahold_d;
  logic          vld_q, vld_d;
  logic [AW-1:0] caddr_q, caddr_d;
  logic [DW-1:0] cdata_q, cdata_d;
  logic          open_now, start, close;

  always_comb begin
    open_now = !strb.cs_n && !strb.we_n && strb.oe_n;
    start    = open_now && !open_q;
    // Close only when a strobe rises. An output-enable abort drops open_q silently.
    close    = open_q && (strb.cs_n || strb.we_n);

    open_d   = open_now;
    ahold_d  = start ? addr : ahold_q;
    vld_d    = close;
    caddr_d  = close ? ahold_q : caddr_q;
    cdata_d  = close ? wdata   : cdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      ahold_q <= '0;
      vld_q   <= 1'b0;
      caddr_q <= '0;
      cdata_q <= '0;
    end else begin
      open_q  <= open_d;
      ahold_q <= ahold_d;
      vld_q   <= vld_d;
      caddr_q <= caddr_d;
      cdata_q <= cdata_d;
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_addr  = caddr_q;
  assign cmd_data  = cdata_q;

  // R9
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_addr) |-> cmd_valid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_data) |-> cmd_valid);

endmodule

// File: rtl/fbf_rd_path.sv
module fbf_rd_path
  import fbf_pkg::*;
#(
  parameter int unsigned  AW     = 18,
  parameter int unsigned  DW     = 8,
  parameter logic [DW-1:0] MFR_ID = 8'hDA,
  parameter logic [DW-1:0] DEV_ID = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strb_t         strb,
  input  logic [AW-1:0] addr,
  input  logic          id_hv,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_en
);

  logic [DW-1:0] id_byte;
  logic [DW-1:0] sel_byte;

  always_comb begin
    unique case (addr[1:0])
      IDSEL_MFR: id_byte = MFR_ID;
      IDSEL_DEV: id_byte = DEV_ID;
      default:   id_byte = '0;
    endcase
    sel_byte = id_hv ? id_byte : arr_rdata;
    rd_en    = !strb.cs_n && !strb.oe_n;
    rd_data  = rd_en ? sel_byte : '0;
  end

  // R2
  released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import fbf_pkg::*;
#(
  parameter int unsigned   AW          = 18,
  parameter int unsigned   DW          = 8,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [DW-1:0] MFR_ID      = 8'hDA,
  parameter logic [DW-1:0] DEV_ID      = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_pin,
  input  logic          oe_n_pin,
  input  logic          we_n_pin,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          id_hv,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_en,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);

  logic [STRB_W-1:0] sync_vec;
  strb_t             strb;

  fbf_sync #(.W(STRB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({cs_n_pin, oe_n_pin, we_n_pin}),
    .sync_o (sync_vec)
  );

  assign strb = strb_t'(sync_vec);

  fbf_rd_path #(.AW(AW), .DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .addr      (addr),
    .id_hv     (id_hv),
    .arr_rdata (arr_rdata),
    .rd_data   (rd_data),
    .rd_en     (rd_en)
  );

  fbf_wr_latch #(.AW(AW), .DW(DW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .addr      (addr),
    .wdata     (wdata),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  // R2
  drive_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> ($past(!cs_n_pin, 2) && $past(!oe_n_pin, 2)));

  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cs_n |-> !rd_en);

endmodule

// File: tb/test_flash_bus_front.sv
module test_flash_bus_front;

  localparam int AW = 18;
  localparam int DW = 8;
  localparam logic [7:0] MFR = 8'hDA;
  localparam logic [7:0] DEV = 8'h0B;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, oe_n, we_n, id_hv;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, arr_rdata;
  logic [DW-1:0] rd_data;
  logic          rd_en, cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int errors = 0;
  int checks = 0;
  int pulses = 0;

  always #10 clk = ~clk;

  flash_bus_front i_flash_bus_front (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .oe_n_pin(oe_n), .we_n_pin(we_n),
    .addr(addr), .wdata(wdata), .id_hv(id_hv), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .rd_en(rd_en), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  // Array model: data is a function of the address.
  assign arr_rdata = addr[7:0] ^ 8'h5A;

  always @(posedge clk) begin
    #2;
    if (rst_n && cmd_valid) pulses++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Write with chosen strobe orders; a1 is the address at the first fall, a2 at the second,
  // d1 the data at the first rise, d2 after it. Abort pulls output enable low mid-cycle.
  task automatic do_write(bit cs_first_fall, bit we_first_rise,
                          logic [AW-1:0] a1, logic [AW-1:0] a2,
                          logic [7:0] d1, logic [7:0] d2, bit abort);
    @(negedge clk);
    addr = a1; wdata = d1;
    if (cs_first_fall) cs_n = 1'b0; else we_n = 1'b0;
    cyc(4);
    addr = a2;
    if (cs_first_fall) we_n = 1'b0; else cs_n = 1'b0;
    cyc(4);
    addr = a2 ^ 18'h3FFFF;
    if (abort) begin oe_n = 1'b0; cyc(4); end
    if (we_first_rise) we_n = 1'b1; else cs_n = 1'b1;
    cyc(4);
    wdata = d2;
    cs_n = 1'b1; we_n = 1'b1;
    cyc(4);
    oe_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int p0;
    rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    id_hv = 1'b0; addr = '0; wdata = '0;
    cyc(3);
    // R1 during reset
    check("R1 rd_en", rd_en, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 cmd_addr/data", {cmd_addr, cmd_data}, 0);
    rst_n = 1'b1;
    cyc(3);
    check("R1 after release", {rd_en, cmd_valid, cmd_addr, cmd_data}, 0);

    // R2 R3 R4: all strobe levels, several addresses
    for (int a = 0; a < 4; a++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        addr = AW'(a * 18'h1235 + 7);
        cs_n = s[2]; oe_n = s[1]; we_n = s[0];
        cyc(3);
        check("R2 rd_en gating", rd_en, (!s[2] && !s[1]));
        if (s[2]) check("R3 standby released", rd_en, 0);
        check("R4 read data", rd_data,
              (!s[2] && !s[1]) ? ((addr[7:0]) ^ 8'h5A) : 8'h00);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        cyc(4);
      end
    end

    // R5: identifier reads, upper bits varied
    @(negedge clk);
    id_hv = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
    cyc(3);
    for (int up = 0; up < 6; up++) begin
      for (int lo = 0; lo < 4; lo++) begin
        @(negedge clk);
        addr = AW'((up * 18'h2A5C4) | lo);
        addr[1:0] = 2'(lo);
        @(negedge clk);
        check("R5 identifier", rd_data, (lo == 0) ? MFR : (lo == 1) ? DEV : 8'h00);
      end
    end
    @(negedge clk);
    id_hv = 1'b0; cs_n = 1'b1; oe_n = 1'b1;
    cyc(4);

    // R9: latency and width of the command pulse
    p0 = pulses;
    @(negedge clk);
    addr = 18'h15555; wdata = 8'hA5; cs_n = 1'b0; we_n = 1'b0;
    cyc(6);
    we_n = 1'b1;
    cyc(2);
    check("R9 no pulse after 2 edges", cmd_valid, 0);
    cyc(1);
    check("R9 pulse after 3 edges", cmd_valid, 1);
    cyc(1);
    check("R9 pulse one cycle", cmd_valid, 0);
    cs_n = 1'b1;
    cyc(5);
    check("R9 one pulse", pulses - p0, 1);
    check("R9 address", cmd_addr, 18'h15555);
    check("R9 data", cmd_data, 8'hA5);

    // R7 R8: all four orderings
    for (int o = 0; o < 4; o++) begin
      logic [AW-1:0] a1, a2;
      logic [7:0] d1, d2;
      a1 = AW'(18'h01000 + o); a2 = AW'(18'h2F000 + 16 * o);
      d1 = 8'(8'h30 + o);      d2 = 8'(8'hC0 + o);
      p0 = pulses;
      do_write(o[0], o[1], a1, a2, d1, d2, 1'b0);
      check("R7 later fall address", cmd_addr, a2);
      check("R8 earlier rise data", cmd_data, d1);
      check("R9 single pulse per write", pulses - p0, 1);
      cyc(3);
      check("R9 values held", {cmd_addr, cmd_data}, {a2, d1});
    end

    // R6: strobes low with output enable low
    p0 = pulses;
    @(negedge clk);
    oe_n = 1'b0;
    cyc(2);
    addr = 18'h00777; wdata = 8'h11; cs_n = 1'b0; we_n = 1'b0;
    cyc(5);
    cs_n = 1'b1; we_n = 1'b1;
    cyc(5);
    oe_n = 1'b1;
    cyc(3);
    check("R6 no command with oe low", pulses - p0, 0);
    check("R6 latch unchanged", {cmd_addr, cmd_data}, {AW'(18'h2F030), 8'h33});

    // R10: output enable pulled low mid-cycle
    p0 = pulses;
    do_write(1'b1, 1'b1, 18'h00ABC, 18'h00DEF, 8'h77, 8'h88, 1'b1);
    check("R10 abort no pulse", pulses - p0, 0);
    check("R10 latch unchanged", {cmd_addr, cmd_data}, {AW'(18'h2F030), 8'h33});

    // R10 follow-up: a normal write still works afterwards
    p0 = pulses;
    do_write(1'b0, 1'b0, 18'h10001, 18'h20002, 8'h5C, 8'hC5, 1'b0);
    check("R10 recovery pulse", pulses - p0, 1);
    check("R10 recovery values", {cmd_addr, cmd_data}, {AW'(18'h20002), 8'h5C});

    finish_run();
  end

endmodule